// File: doc/BRIEF.md
# SONET Transmit Frame Multiplexer with Alarm Indication

This block assembles the outgoing byte stream of a SONET frame, one byte per clock, ahead of the scrambler. A raster counter walks the frame row by row. For each byte slot the block picks one of three things: a transport-overhead byte from an external overhead source, a byte of an ATM cell taken from a small cell buffer, or an all-ones filler. The current slot position is presented on `slot_row`/`slot_col` so that the overhead source can supply the matching byte in the same cycle. The chosen byte appears on `tx_byte` one clock later.

Two alarm indication modes replace parts of the frame with all ones before scrambling. Line alarm keeps only the section overhead rows valid. Path alarm blanks the pointer row of the overhead and the whole payload envelope, and keeps the other overhead bytes. In both alarm modes no cell bytes are consumed. The cell buffer (three cells deep) therefore fills and pushes back on the cell source until normal operation returns. A requested mode is sampled only on the last slot of a frame, so a frame is always wholly of one kind.

Top module: `sonet_tx_ais_mux`

## Requirements
- R1: While `rst` is high (synchronous, active high), `tx_byte` is 0, `tx_sof` is 0, `cell_ready` is 1 and the slot position is row 0, column 0. Mode is normal.
- R2: Slots advance one per clock in row-major order over ROWS x COLS slots and then wrap to row 0, column 0. `tx_byte` and `tx_sof` present the slot shown on `slot_row`/`slot_col` one clock later. `tx_sof` is 1 only for slot (0,0).
- R3: In normal mode, a slot with column < TOH_COLS carries `toh_byte`, and every other slot is a payload slot.
- R4: A payload slot in normal mode carries the next cell byte in write order. A new 53-byte cell starts only when the buffer holds at least one whole cell. Once a cell is started, its remaining bytes fill the following payload slots. Otherwise the slot carries the idle byte 8'h6A.
- R5: With `ais_req` = 2'b01 (line alarm), overhead slots in rows 0..SOH_ROWS-1 (default rows 0 to 2) carry `toh_byte`, and every other slot is 8'hFF.
- R6: With `ais_req` = 2'b10 (path alarm), overhead slots in row PTR_ROW (default 3, zero-based) and all payload slots are 8'hFF. All other overhead slots carry `toh_byte`.
- R7: `ais_req` = 2'b11 is treated as line alarm. 2'b00 is normal.
- R8: `ais_req` is sampled only on the last slot of a frame, and it governs the whole next frame from slot (0,0) onward.
- R9: While either alarm mode is active, no byte is removed from the cell buffer. After normal mode returns, cells are inserted again in their original order.
- R10: The buffer holds CELLS x 53 bytes (default 159). `cell_ready` is low exactly when it is full. A byte offered with `cell_ready` low is not stored.
- R11: A byte on `cell_data` is stored when `cell_valid` and `cell_ready` are both high at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| ais_req | input | 2 | Requested mode: 00 normal, 01 line alarm, 10 path alarm, 11 line alarm |
| toh_byte | input | 8 | Overhead byte for the slot on slot_row/slot_col |
| slot_row | output | ROW_W | Row of the slot being built this cycle |
| slot_col | output | COL_W | Column of the slot being built this cycle |
| cell_valid | input | 1 | Cell byte offered |
| cell_data | input | 8 | Cell byte |
| cell_ready | output | 1 | Buffer has room for a byte |
| tx_byte | output | 8 | Outgoing frame byte, before scrambling |
| tx_sof | output | 1 | High with the first byte of a frame |

## Verification
The hardest situation to reach is a full buffer that backs up the cell source across an alarm. It must then drain in the original order once normal frames return, while the source keeps offering bytes that must be dropped. The bench gets there with a short geometry of 9 x 30 slots. It raises the alarm request in the middle of a frame and steps through line, coded-11, and path alarm frames while offering a byte every clock. It drives a marker value whenever `cell_ready` is low, so a stored rejected byte would show up later in the payload. A sparse early phase lets the buffer run short of a whole cell, which makes idle bytes appear between cells.

// File: rtl/sonet_tx_pkg.sv
package sonet_tx_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'b00,
    MODE_LINE_AIS = 2'b01,
    MODE_PATH_AIS = 2'b10
  } tx_mode_e;

  localparam logic [7:0] FILL_ONES = 8'hFF;

  // request code 11 maps onto line alarm
  function automatic tx_mode_e decode_req(input logic [1:0] req);
    case (req)
      2'b00:   decode_req = MODE_NORMAL;
      2'b10:   decode_req = MODE_PATH_AIS;
      default: decode_req = MODE_LINE_AIS;
    endcase
  endfunction
endpackage

// File: rtl/frame_raster.sv
module frame_raster #(
  parameter int ROWS = 9,
  parameter int COLS = 270,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             first,
  output logic             last
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  assign first = (row == '0) && (col == '0);
  assign last  = (row == ROW_LAST) && (col == COL_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      row <= '0;
      col <= '0;
    end else if (col == COL_LAST) begin
      col <= '0;
      row <= (row == ROW_LAST) ? '0 : row + 1'b1;
    end else begin
      col <= col + 1'b1;
    end
  end

  AST_RASTER_WRAP: assert property (@(posedge clk) disable iff (rst)
    last |=> (row == '0 && col == '0)); // R2
endmodule

// File: rtl/cell_buffer.sv
module cell_buffer #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 159,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  assign full = (count == CNT_W'(DEPTH));
  assign dout = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0); // R4
endmodule

// File: rtl/slot_classifier.sv
module slot_classifier
  import sonet_tx_pkg::*;
#(
  parameter int ROW_W    = 4,
  parameter int COL_W    = 9,
  parameter int TOH_COLS = 9,
  parameter int SOH_ROWS = 3,
  parameter int PTR_ROW  = 3
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  tx_mode_e         mode,
  output logic             take_toh,
  output logic             take_ones,
  output logic             payload_slot
);
  logic in_toh, in_soh, in_ptr;

  assign in_toh = (col < COL_W'(TOH_COLS));
  assign in_soh = in_toh && (row < ROW_W'(SOH_ROWS));
  assign in_ptr = in_toh && (row == ROW_W'(PTR_ROW));

  always_comb begin
    take_toh     = 1'b0;
    take_ones    = 1'b0;
    payload_slot = 1'b0;
    case (mode)
      MODE_LINE_AIS: begin
        take_toh  = in_soh;
        take_ones = !in_soh;
      end
      MODE_PATH_AIS: begin
        take_toh  = in_toh && !in_ptr;
        take_ones = !(in_toh && !in_ptr);
      end
      default: begin
        take_toh     = in_toh;
        payload_slot = !in_toh;
      end
    endcase
  end
endmodule

// File: rtl/sonet_tx_ais_mux.sv
module sonet_tx_ais_mux
  import sonet_tx_pkg::*;
#(
  parameter int ROWS       = 9,
  parameter int COLS       = 270,
  parameter int TOH_COLS   = 9,
  parameter int SOH_ROWS   = 3,
  parameter int PTR_ROW    = 3,
  parameter int CELL_BYTES = 53,
  parameter int CELLS      = 3,
  parameter logic [7:0] IDLE_BYTE = 8'h6A,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ais_req,
  input  logic [7:0]       toh_byte,
  output logic [ROW_W-1:0] slot_row,
  output logic [COL_W-1:0] slot_col,
  input  logic             cell_valid,
  input  logic [7:0]       cell_data,
  output logic             cell_ready,
  output logic [7:0]       tx_byte,
  output logic             tx_sof
);
  localparam int DEPTH = CELLS * CELL_BYTES;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int POS_W = (CELL_BYTES > 1) ? $clog2(CELL_BYTES) : 1;

  tx_mode_e         mode_q;
  logic             frame_first, frame_last;
  logic             take_toh, take_ones, payload_slot;
  logic             fifo_push, fifo_pop, fifo_full;
  logic [7:0]       fifo_dout;
  logic [CNT_W-1:0] fifo_count;
  logic [POS_W-1:0] cell_pos;
  logic [7:0]       next_byte;

  frame_raster #(.ROWS(ROWS), .COLS(COLS)) u_raster (
    .clk(clk), .rst(rst), .row(slot_row), .col(slot_col),
    .first(frame_first), .last(frame_last)
  );

  slot_classifier #(
    .ROW_W(ROW_W), .COL_W(COL_W), .TOH_COLS(TOH_COLS),
    .SOH_ROWS(SOH_ROWS), .PTR_ROW(PTR_ROW)
  ) u_classify (
    .row(slot_row), .col(slot_col), .mode(mode_q),
    .take_toh(take_toh), .take_ones(take_ones), .payload_slot(payload_slot)
  );

  assign cell_ready = !fifo_full;
  assign fifo_push  = cell_valid && !fifo_full;

  cell_buffer #(.WIDTH(8), .DEPTH(DEPTH)) u_cells (
    .clk(clk), .rst(rst), .push(fifo_push), .din(cell_data),
    .pop(fifo_pop), .dout(fifo_dout), .count(fifo_count), .full(fifo_full)
  );

  // continue a started cell, or start one only if a whole cell is waiting
  assign fifo_pop = payload_slot &&
                    ((cell_pos != '0) || (fifo_count >= CNT_W'(CELL_BYTES)));

  always_comb begin
    if (take_ones)     next_byte = FILL_ONES;
    else if (take_toh) next_byte = toh_byte;
    else if (fifo_pop) next_byte = fifo_dout;
    else               next_byte = IDLE_BYTE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_byte  <= '0;
      tx_sof   <= 1'b0;
      cell_pos <= '0;
      mode_q   <= MODE_NORMAL;
    end else begin
      tx_byte <= next_byte;
      tx_sof  <= frame_first;
      if (fifo_pop)
        cell_pos <= (cell_pos == POS_W'(CELL_BYTES - 1)) ? '0 : cell_pos + 1'b1;
      if (frame_last)
        mode_q <= decode_req(ais_req);
    end
  end

  AST_NO_POP_IN_AIS: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_NORMAL) |-> !fifo_pop); // R9
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_last |=> $stable(mode_q)); // R8
  AST_LINE_ONES: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LINE_AIS && slot_row >= ROW_W'(SOH_ROWS)) |=> tx_byte == 8'hFF); // R5
  AST_PATH_PTR_ONES: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_PATH_AIS && slot_row == ROW_W'(PTR_ROW)) |=> tx_byte == 8'hFF); // R6
  AST_SOF_POSITION: assert property (@(posedge clk) disable iff (rst)
    tx_sof |-> (slot_row == '0 && slot_col == COL_W'(1 % COLS))); // R2
endmodule

// File: tb/sonet_tx_ais_mux_test.sv
module sonet_tx_ais_mux_test;
  localparam int PERIOD = 10;
  localparam int ROWS = 9, COLS = 30, TOH = 3, SOH = 3, PTR = 3;
  localparam int CELL = 53, CELLS = 3, DEPTH = CELL * CELLS;
  localparam int FRAME = ROWS * COLS;
  localparam int NFRAMES = 10;
  localparam logic [7:0] IDLE = 8'h6A;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] ais_req = 2'b00;
  logic [7:0] toh_byte;
  logic [3:0] slot_row;
  logic [4:0] slot_col;
  logic cell_valid = 1'b0;
  logic [7:0] cell_data = 8'h00;
  logic cell_ready, tx_sof;
  logic [7:0] tx_byte;

  int vectors = 0, fails = 0;
  bit done = 0;

  // model state
  logic [7:0] q [0:8191];
  int wr = 0, rd = 0, r = 0, c = 0, pos = 0, mode = 0, next_k = 1;
  bit have_exp = 0;
  logic [7:0] e_byte;
  bit e_sof;

  always #(PERIOD/2) clk = ~clk;

  assign toh_byte = 8'h10 * slot_row + {3'b0, slot_col} + 8'h01;

  sonet_tx_ais_mux #(
    .ROWS(ROWS), .COLS(COLS), .TOH_COLS(TOH), .SOH_ROWS(SOH), .PTR_ROW(PTR),
    .CELL_BYTES(CELL), .CELLS(CELLS), .IDLE_BYTE(IDLE)
  ) uut (
    .clk(clk), .rst(rst), .ais_req(ais_req), .toh_byte(toh_byte),
    .slot_row(slot_row), .slot_col(slot_col), .cell_valid(cell_valid),
    .cell_data(cell_data), .cell_ready(cell_ready), .tx_byte(tx_byte), .tx_sof(tx_sof)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] sched(input int f);
    case (f)
      3, 4:    sched = 2'b01; // R5 line alarm
      5:       sched = 2'b11; // R7 coded as line
      6:       sched = 2'b10; // R6 path alarm
      default: sched = 2'b00;
    endcase
  endfunction

  task automatic step(input int n);
    int f, cnt;
    bit push, in_toh, in_soh, in_ptr, pop;
    logic [7:0] toh;
    if (have_exp) begin
      chk(tx_byte == e_byte, "R3/R4/R5/R6/R9 tx_byte", tx_byte, e_byte);
      chk(tx_sof == e_sof, "R2 tx_sof", tx_sof, e_sof);
    end
    cnt = wr - rd;
    chk(cell_ready == (cnt < DEPTH), "R10 cell_ready", cell_ready, cnt < DEPTH);
    chk(slot_row == r && slot_col == c, "R2 slot position", {slot_row, 3'b0, slot_col}, r * 256 + c);
    // drive inputs
    f = n / FRAME;
    ais_req = sched((n + FRAME / 2) / FRAME); // changes mid-frame, R8
    cell_valid = (f == 0) ? (n % 4 == 0) : (f == 7) ? (n % 3 != 0) : 1'b1;
    cell_data = (cnt < DEPTH) ? 8'(next_k) : 8'hEE; // R11, R10 marker
    push = cell_valid && (cnt < DEPTH);
    // expected slot result
    toh = 8'(16 * r + c + 1);
    in_toh = c < TOH;
    in_soh = in_toh && r < SOH;
    in_ptr = in_toh && r == PTR;
    pop = 0;
    if (mode == 1) e_byte = in_soh ? toh : 8'hFF;
    else if (mode == 2) e_byte = (in_toh && !in_ptr) ? toh : 8'hFF;
    else if (in_toh) e_byte = toh;
    else if (pos != 0 || cnt >= CELL) begin
      pop = 1;
      e_byte = q[rd];
    end else e_byte = IDLE;
    e_sof = (r == 0 && c == 0);
    have_exp = 1;
    // update model
    if (pop) begin
      rd++;
      pos = (pos == CELL - 1) ? 0 : pos + 1;
    end
    if (push) begin
      q[wr] = 8'(next_k);
      wr++;
      next_k = (next_k == 200) ? 1 : next_k + 1;
    end
    if (r == ROWS - 1 && c == COLS - 1)
      mode = (ais_req == 2'b00) ? 0 : (ais_req == 2'b10) ? 2 : 1;
    if (c == COLS - 1) begin
      c = 0;
      r = (r == ROWS - 1) ? 0 : r + 1;
    end else c++;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tx_byte == 8'h00, "R1 tx_byte in reset", tx_byte, 0);
    chk(tx_sof == 1'b0, "R1 tx_sof in reset", tx_sof, 0);
    chk(cell_ready == 1'b1, "R1 cell_ready in reset", cell_ready, 1);
    chk(slot_row == 0 && slot_col == 0, "R1 slot in reset", slot_col, 0);
    rst = 1'b0;
    for (int n = 0; n < NFRAMES * FRAME; n++) begin
      step(n);
      @(negedge clk);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule